// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Set/Clear Masks

This block gathers up to sixteen level-type interrupt requests from peripherals and gives the processor one winner at a time. Each source carries its own 4-bit priority. A source takes part in arbitration only when all of these hold:

- its request is high;
- its mask bit is clear;
- its priority is non-zero;
- its priority exceeds a programmable user threshold;
- the global mask-all control is off.

Among the sources that take part, the one with the highest priority wins. When priorities are equal, the lower index wins. The winner's priority and index are registered and driven to the processor together with a valid flag.

Software programs the block over a flat register bus with address, write data, write enable, read enable and read data. The threshold register is protected: a write only lands when the top byte of the data carries a fixed key. Masks are changed through two separate write-one registers, one that sets bits and one that clears them, so no read-modify-write is ever needed. A separate non-maskable path latches rising edges of the NMI pin into a sticky flag. It forwards that flag to the processor unless the processor's block bit is set and the pass-through control is off.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all priorities, masks, the threshold, both control bits and the NMI flag are zero, and irq_valid_o, irq_level_o, irq_id_o and nmi_o are low.
- R2: The priority of source k sits at register address k/4, bits [4*(k%4)+3 : 4*(k%4)], and reads back as written.
- R3: The block presents the eligible source with the largest priority: irq_level_o carries that priority and irq_id_o its index. Among equal priorities the lowest index wins.
- R4: A source whose priority is 0 is never selected.
- R5: Writing the mask-set register (address 4) masks each source whose data bit is 1. Zero bits leave their mask unchanged. Reading address 4 returns the mask vector in bits [15:0].
- R6: Writing the mask-clear register (address 5) unmasks each source whose data bit is 1. Zero bits are ignored. Reading address 5 returns zero.
- R7: A write to the threshold register (address 6) loads bits [3:0] only when bits [31:24] equal 0xA5. Any other write leaves it unchanged. A read returns the threshold in bits [3:0].
- R8: A source is eligible only when its priority is strictly greater than the threshold.
- R9: While bit 0 of the control register (address 7) is set, irq_valid_o stays low.
- R10: irq_valid_o, irq_level_o and irq_id_o are registered. They reflect request, mask, priority, threshold and control state one clock edge after that state changes.
- R11: The NMI status register (address 8) shows the live NMI pin in bit 0. Bit 1 holds a flag that is set one edge after a rising edge on the pin, stays set after the pin falls, and is cleared by writing 1 to bit 1.
- R12: nmi_o equals the NMI flag while cpu_block_i is low. While cpu_block_i is high, nmi_o equals the flag only if bit 1 of the control register is set; otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Level interrupt requests, one per source |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| cpu_block_i | input | 1 | Processor block bit |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data; zero when re_i is low |
| irq_valid_o | output | 1 | An eligible request is being presented |
| irq_level_o | output | 4 | Priority of the presented request |
| irq_id_o | output | 4 | Index of the presented request |
| nmi_o | output | 1 | Non-maskable request to the processor |

## Verification
The bench uses the default build: sixteen sources, 4-bit priorities and four priority registers of four fields each. This puts a single source, two sources with different priorities and a tie at the top priority into one register pair, so the bench can place them side by side. With a 4-bit threshold, the case of a priority equal to the threshold and the case of a priority one above it are both reachable with the same sources. The keyed write, both mask registers and the NMI routing under the block bit are driven through the bus, and each result is observed at the ports.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // key expected in the top byte of a threshold write
    localparam logic [7:0] THR_KEY = 8'hA5;

    // register offsets that follow the block of priority registers
    typedef enum logic [2:0] {
        OFS_MSET = 3'd0,
        OFS_MCLR = 3'd1,
        OFS_THR  = 3'd2,
        OFS_CTRL = 3'd3,
        OFS_NMI  = 3'd4
    } reg_ofs_e;

    localparam int CTRL_MASK_ALL_BIT = 0;
    localparam int CTRL_NMI_THRU_BIT = 1;
    localparam int NMI_LIVE_BIT      = 0;
    localparam int NMI_FLAG_BIT      = 1;
endpackage

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0]             mask,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thr,
    input  logic                           mask_all,
    output logic                           hit,
    output logic [PRIO_W-1:0]              level,
    output logic [ID_W-1:0]                id
);
    logic [NUM_SRC-1:0] elig;

    // per-source eligibility: requested, unmasked, above threshold
    // (a zero priority can never exceed any threshold, so it drops out)
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_elig
        assign elig[k] = req[k] && !mask[k] && !mask_all
                         && (prio[k] != '0) && (prio[k] > thr);
    end

    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        hit   = 1'b0;
        level = '0;
        id    = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (elig[k] && (prio[k] > level)) begin
                hit   = 1'b1;
                level = prio[k];
                id    = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/intc_nmi_path.sv
module intc_nmi_path (
    input  logic pin,
    input  logic pin_prev_q,
    input  logic flag_q,
    input  logic clr,
    input  logic cpu_block,
    input  logic thru_block,
    output logic flag_d,
    output logic nmi_out
);
    logic rise;

    always_comb begin
        rise    = pin && !pin_prev_q;
        // a fresh edge wins over a clear in the same cycle
        flag_d  = rise || (flag_q && !clr);
        nmi_out = flag_q && (!cpu_block || thru_block);
    end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int FPR     = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           re,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [NUM_SRC-1:0]             mask,
    input  logic [PRIO_W-1:0]              thr,
    input  logic                           mask_all,
    input  logic                           nmi_thru,
    input  logic                           nmi_pin,
    input  logic                           nmi_flag,
    output logic [DATA_W-1:0]              rdata
);
    import intc_pkg::*;

    localparam int NPR = NUM_SRC / FPR;

    always_comb begin
        rdata = '0;
        if (re) begin
            for (int r = 0; r < NPR; r++) begin
                if (addr == ADDR_W'(r)) begin
                    for (int f = 0; f < FPR; f++) begin
                        rdata[f*PRIO_W +: PRIO_W] = prio[r*FPR + f];
                    end
                end
            end
            if (addr == ADDR_W'(NPR + int'(OFS_MSET))) begin
                rdata[NUM_SRC-1:0] = mask;
            end
            // the clear register reads as zero
            if (addr == ADDR_W'(NPR + int'(OFS_THR))) begin
                rdata[PRIO_W-1:0] = thr;
            end
            if (addr == ADDR_W'(NPR + int'(OFS_CTRL))) begin
                rdata[CTRL_MASK_ALL_BIT] = mask_all;
                rdata[CTRL_NMI_THRU_BIT] = nmi_thru;
            end
            if (addr == ADDR_W'(NPR + int'(OFS_NMI))) begin
                rdata[NMI_LIVE_BIT] = nmi_pin;
                rdata[NMI_FLAG_BIT] = nmi_flag;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int PREG_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic                      nmi_i,
    input  logic                      cpu_block_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic                      we_i,
    input  logic                      re_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic                      irq_valid_o,
    output logic [PRIO_W-1:0]         irq_level_o,
    output logic [$clog2(NUM_SRC)-1:0] irq_id_o,
    output logic                      nmi_o
);
    import intc_pkg::*;

    localparam int ID_W   = $clog2(NUM_SRC);
    localparam int FPR    = PREG_W / PRIO_W;
    localparam int NPR    = NUM_SRC / FPR;
    localparam int A_MSET = NPR + int'(OFS_MSET);
    localparam int A_MCLR = NPR + int'(OFS_MCLR);
    localparam int A_THR  = NPR + int'(OFS_THR);
    localparam int A_CTRL = NPR + int'(OFS_CTRL);
    localparam int A_NMI  = NPR + int'(OFS_NMI);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0]             mask;
        logic [PRIO_W-1:0]              thr;
        logic                           mask_all;
        logic                           nmi_thru;
        logic                           nmi_prev;
        logic                           nmi_flag;
        logic                           irq_valid;
        logic [PRIO_W-1:0]              irq_level;
        logic [ID_W-1:0]                irq_id;
    } state_t;

    state_t st_d, st_q;

    logic              arb_hit;
    logic [PRIO_W-1:0] arb_level;
    logic [ID_W-1:0]   arb_id;
    logic              nmi_clr;
    logic              nmi_flag_d;

    intc_prio_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .req      (req_i),
        .mask     (st_q.mask),
        .prio     (st_q.prio),
        .thr      (st_q.thr),
        .mask_all (st_q.mask_all),
        .hit      (arb_hit),
        .level    (arb_level),
        .id       (arb_id)
    );

    assign nmi_clr = we_i && (addr_i == ADDR_W'(A_NMI)) && wdata_i[NMI_FLAG_BIT];

    intc_nmi_path u_nmi (
        .pin        (nmi_i),
        .pin_prev_q (st_q.nmi_prev),
        .flag_q     (st_q.nmi_flag),
        .clr        (nmi_clr),
        .cpu_block  (cpu_block_i),
        .thru_block (st_q.nmi_thru),
        .flag_d     (nmi_flag_d),
        .nmi_out    (nmi_o)
    );

    intc_read_mux #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .FPR     (FPR),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_rd (
        .addr     (addr_i),
        .re       (re_i),
        .prio     (st_q.prio),
        .mask     (st_q.mask),
        .thr      (st_q.thr),
        .mask_all (st_q.mask_all),
        .nmi_thru (st_q.nmi_thru),
        .nmi_pin  (nmi_i),
        .nmi_flag (st_q.nmi_flag),
        .rdata    (rdata_o)
    );

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int r = 0; r < NPR; r++) begin
                if (addr_i == ADDR_W'(r)) begin
                    for (int f = 0; f < FPR; f++) begin
                        st_d.prio[r*FPR + f] = wdata_i[f*PRIO_W +: PRIO_W];
                    end
                end
            end
            if (addr_i == ADDR_W'(A_MSET)) begin
                st_d.mask = st_q.mask | wdata_i[NUM_SRC-1:0];
            end
            if (addr_i == ADDR_W'(A_MCLR)) begin
                st_d.mask = st_q.mask & ~wdata_i[NUM_SRC-1:0];
            end
            if ((addr_i == ADDR_W'(A_THR)) && (wdata_i[DATA_W-1 -: 8] == THR_KEY)) begin
                st_d.thr = wdata_i[PRIO_W-1:0];
            end
            if (addr_i == ADDR_W'(A_CTRL)) begin
                st_d.mask_all = wdata_i[CTRL_MASK_ALL_BIT];
                st_d.nmi_thru = wdata_i[CTRL_NMI_THRU_BIT];
            end
        end
        st_d.nmi_prev  = nmi_i;
        st_d.nmi_flag  = nmi_flag_d;
        st_d.irq_valid = arb_hit;
        st_d.irq_level = arb_level;
        st_d.irq_id    = arb_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_valid_o = st_q.irq_valid;
    assign irq_level_o = st_q.irq_level;
    assign irq_id_o    = st_q.irq_id;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int A_MSET  = 4,
    parameter int A_THR   = 6,
    parameter int A_NMI   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         req_i,
    input logic [ADDR_W-1:0]          addr_i,
    input logic [DATA_W-1:0]          wdata_i,
    input logic                       we_i,
    input logic                       irq_valid_o,
    input logic [PRIO_W-1:0]          irq_level_o,
    input logic [$clog2(NUM_SRC)-1:0] irq_id_o,
    input logic [NUM_SRC-1:0]         mask,
    input logic [PRIO_W-1:0]          thr,
    input logic                       mask_all,
    input logic                       nmi_flag
);
    // presented source had its request high on the deciding edge
    assert_winner_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> |($past(req_i) & (NUM_SRC'(1) << irq_id_o)));

    assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_level_o != '0));

    assert_set_masks_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(A_MSET))
        |=> ((mask & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

    assert_bad_key_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(A_THR) && wdata_i[DATA_W-1 -: 8] != 8'hA5)
        |=> $stable(thr));

    assert_level_above_thr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_level_o > $past(thr)));

    assert_mask_all_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_all) |-> !irq_valid_o);

    assert_nmi_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag && !(we_i && addr_i == ADDR_W'(A_NMI) && wdata_i[1])) |=> nmi_flag);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .A_MSET  (A_MSET),
    .A_THR   (A_THR),
    .A_NMI   (A_NMI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .we_i        (we_i),
    .irq_valid_o (irq_valid_o),
    .irq_level_o (irq_level_o),
    .irq_id_o    (irq_id_o),
    .mask        (st_q.mask),
    .thr         (st_q.thr),
    .mask_all    (st_q.mask_all),
    .nmi_flag    (st_q.nmi_flag)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic        nmi_i = 1'b0;
    logic        cpu_block_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        we_i = 1'b0;
    logic        re_i = 1'b0;
    logic [31:0] rdata_o;
    logic        irq_valid_o;
    logic [3:0]  irq_level_o;
    logic [3:0]  irq_id_o;
    logic        nmi_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .nmi_i       (nmi_i),
        .cpu_block_i (cpu_block_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .we_i        (we_i),
        .re_i        (re_i),
        .rdata_o     (rdata_o),
        .irq_valid_o (irq_valid_o),
        .irq_level_o (irq_level_o),
        .irq_id_o    (irq_id_o),
        .nmi_o       (nmi_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i = a; re_i = 1'b1;
        #1;
        d = rdata_o;
        re_i = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 valid", 32'(irq_valid_o), 0);
        chk("R1 level/id", {irq_level_o, irq_id_o}, 0);
        chk("R1 nmi_o", 32'(nmi_o), 0);
        rd(4'd4, v); chk("R1 mask", v, 0);
        rd(4'd6, v); chk("R1 thr", v, 0);
        rd(4'd0, v); chk("R1 prio0", v, 0);
    endtask

    task automatic t_prio_zero();
        req_i = 16'h008C;
        settle(); settle();
        chk("R4 zero priority never picked", 32'(irq_valid_o), 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(4'd0, 32'h0000_5000);
        settle();
        chk("R3 single valid/level/id", {irq_valid_o, irq_level_o, irq_id_o}, {1'b1, 4'd5, 4'd3});
        rd(4'd0, v); chk("R2 field layout reg0", v, 32'h5000);
    endtask

    task automatic t_highest();
        wr(4'd1, 32'h0000_9000);
        settle();
        chk("R3 highest wins", {irq_level_o, irq_id_o}, {4'd9, 4'd7});
    endtask

    task automatic t_tie();
        logic [31:0] v;
        wr(4'd0, 32'h0000_5900);
        settle();
        chk("R3 tie lowest index", {irq_level_o, irq_id_o}, {4'd9, 4'd2});
        rd(4'd1, v); chk("R2 field layout reg1", v, 32'h9000);
    endtask

    task automatic t_mask_set();
        logic [31:0] v;
        wr(4'd4, 32'h0000_0004);
        settle();
        chk("R5 masked source skipped", {irq_level_o, irq_id_o}, {4'd9, 4'd7});
        wr(4'd4, 32'h0000_0000);
        settle();
        rd(4'd4, v); chk("R5 zero write no effect", v, 32'h4);
        chk("R5 output unchanged", 32'(irq_id_o), 7);
    endtask

    task automatic t_mask_clr();
        logic [31:0] v;
        wr(4'd5, 32'h0000_0000);
        settle();
        rd(4'd4, v); chk("R6 zero write ignored", v, 32'h4);
        rd(4'd5, v); chk("R6 clear reg reads zero", v, 0);
        wr(4'd5, 32'h0000_0004);
        settle();
        chk("R6 unmasked source back", {irq_level_o, irq_id_o}, {4'd9, 4'd2});
        rd(4'd4, v); chk("R6 mask cleared", v, 0);
    endtask

    task automatic t_thr();
        logic [31:0] v;
        wr(4'd6, 32'h5A00_0009);
        settle();
        rd(4'd6, v); chk("R7 bad key dropped", v, 0);
        chk("R7 output unaffected", 32'(irq_valid_o), 1);
        wr(4'd6, 32'hA500_0009);
        settle();
        rd(4'd6, v); chk("R7 keyed write lands", v, 9);
        chk("R8 equal to threshold rejected", 32'(irq_valid_o), 0);
        wr(4'd6, 32'hA500_0008);
        settle();
        chk("R8 above threshold accepted", {irq_valid_o, irq_level_o, irq_id_o}, {1'b1, 4'd9, 4'd2});
        wr(4'd6, 32'hA500_0000);
        settle();
    endtask

    task automatic t_mask_all();
        wr(4'd7, 32'h1);
        settle();
        chk("R9 mask-all blocks", 32'(irq_valid_o), 0);
        wr(4'd7, 32'h0);
        settle();
        chk("R9 released", 32'(irq_valid_o), 1);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_i = 16'h0008;
        #1;
        chk("R10 no change before edge", 32'(irq_id_o), 2);
        @(negedge clk);
        chk("R10 updated after one edge", {irq_level_o, irq_id_o}, {4'd5, 4'd3});
    endtask

    task automatic t_nmi();
        logic [31:0] v;
        @(negedge clk);
        nmi_i = 1'b1;
        rd(4'd8, v); chk("R11 live pin, flag not yet", v, 32'h1);
        @(negedge clk);
        chk("R12 flag drives nmi_o", 32'(nmi_o), 1);
        nmi_i = 1'b0;
        @(negedge clk);
        rd(4'd8, v); chk("R11 flag sticky after pin low", v, 32'h2);
        cpu_block_i = 1'b1;
        #1;
        chk("R12 blocked without pass-through", 32'(nmi_o), 0);
        wr(4'd7, 32'h2);
        #1;
        chk("R12 pass-through under block", 32'(nmi_o), 1);
        wr(4'd8, 32'h2);
        #1;
        chk("R11 flag cleared", 32'(nmi_o), 0);
        rd(4'd8, v); chk("R11 status after clear", v, 0);
        cpu_block_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prio_zero();
        t_single();
        t_highest();
        t_tie();
        t_mask_set();
        t_mask_clr();
        t_thr();
        t_mask_all();
        t_latency();
        t_nmi();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule